// File: doc/BRIEF.md
# DDR Rank Command Timing Guard

This block sits between the command scheduler of a memory controller and the DRAM command bus of one rank. The scheduler offers one command at a time: an activate (ACT), read (RD), write (WR) or precharge (PRE). The guard checks the offered command against the rank's spacing rules, which are counted in DRAM clock cycles. It accepts the command in the first cycle in which every rule that applies to it is met. Until then it holds the command back.

Four rules are enforced. The first is the minimum spacing between two ACTs. The second is a rolling window that admits at most four ACTs. The third is the turnaround from a write to a following read. The fourth is the spacing from a read to a precharge. All four values come from a 32-bit configuration word. Each field is clamped to its legal range before use. Every interval is timed with the values in force when the earlier command was accepted, so a configuration change never moves spacing that is already being counted.

The command side is valid/ready. `cmd_ready` shows whether the command type now on `cmd_type` would be legal in this cycle, and it does not depend on `cmd_valid`. A command is accepted when `cmd_valid` and `cmd_ready` are both high at a rising clock edge. While the command is held back, the scheduler keeps `cmd_valid` and `cmd_type` steady. The scheduler may also change the offer, because readiness is worked out again every cycle for whatever type is present.

Top module: `rank_cmd_gate`

## Requirements
- R1: After reset no interval is pending, so `cmd_ready` is high for every command type and the first command of each type is accepted at once.
- R2: Two accepted ACTs are at least G cycles apart, with the acceptance cycle counted as cycle 0. G is cfg_word[3:0] clamped to the range 4..7. A held ACT is accepted exactly at cycle G when no other rule blocks it.
- R3: An ACT is held while four earlier ACTs each still lie within their own window. A window is W cycles long, counted from that ACT's acceptance. The held ACT is accepted in the first cycle in which one of the four windows has run out.
- R4: A RD is accepted no earlier than T cycles after the last accepted WR. T is cfg_word[15:12] clamped to 4..8.
- R5: A PRE is accepted no earlier than P cycles after the last accepted RD. P is cfg_word[7:4] clamped to 4..8.
- R6: A WR is never held back. Each rule holds back only the command type it names.
- R7: A field value below its legal range is used as the lower bound, and a value above its legal range is used as the upper bound.
- R8: W is cfg_word[23:16] capped at 63. If that result is below 4×G, W is raised to 4×G. Bits 31:24 and 11:8 are ignored.
- R9: A change of cfg_word affects only intervals that begin after the change. An interval already being counted keeps the value it started with.
- R10: The command codes on cmd_type are ACT=0, RD=1, WR=2 and PRE=3. A command is accepted only when cmd_valid and cmd_ready are both high. A cycle with cmd_valid low starts no interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Timing configuration word; the reset value is 0x0010_4044 |
| cmd_valid | input | 1 | The scheduler is offering a command |
| cmd_type | input | 2 | Code of the offered command |
| cmd_ready | output | 1 | The offered command type is legal in this cycle |

## Verification
A wrong internal count shows up at the ports as an acceptance cycle that is off. `cmd_ready` rises for a held command either earlier or later than the interval computed from the configuration. A corrupted activate window shows up no later than the fifth ACT in a back-to-back burst. A counter stuck at zero shows up on the very next command of the type it guards. The bench therefore records the exact cycle of every acceptance and compares each gap with a value worked out arithmetically, over every field value and over a grid of window settings.

// File: rtl/rcg_pkg.sv
`timescale 1ns/1ps
package rcg_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  localparam int TW        = 6;   // width of every timing count
  localparam int RRD_MIN   = 4;
  localparam int RRD_MAX   = 7;
  localparam int TURN_MIN  = 4;
  localparam int TURN_MAX  = 8;
  localparam int WIN_MAX   = 63;
  localparam int ACT_LIMIT = 4;

  function automatic logic [TW-1:0] clampf(input logic [7:0] v, input int lo, input int hi);
    int x;
    x = int'(v);
    if (x < lo) x = lo;
    if (x > hi) x = hi;
    return TW'(x);
  endfunction
endpackage

// File: rtl/rcg_cfg_clamp.sv
`timescale 1ns/1ps
module rcg_cfg_clamp
  import rcg_pkg::*;
(
  input  logic [31:0]   cfg_word,
  output logic [TW-1:0] rrd_q,
  output logic [TW-1:0] win_q,
  output logic [TW-1:0] w2r_q,
  output logic [TW-1:0] r2p_q
);
  logic [TW-1:0] win_raw;
  logic [TW-1:0] win_floor;
  logic          unused_bits;

  assign unused_bits = ^{cfg_word[31:24], cfg_word[11:8]};

  always_comb begin
    rrd_q     = clampf({4'd0, cfg_word[3:0]},   RRD_MIN,  RRD_MAX);
    r2p_q     = clampf({4'd0, cfg_word[7:4]},   TURN_MIN, TURN_MAX);
    w2r_q     = clampf({4'd0, cfg_word[15:12]}, TURN_MIN, TURN_MAX);
    win_raw   = clampf(cfg_word[23:16], 0, WIN_MAX);
    win_floor = {rrd_q[TW-3:0], 2'b00};
    win_q     = (win_raw < win_floor) ? win_floor : win_raw;
  end
endmodule

// File: rtl/rcg_gap_timer.sv
`timescale 1ns/1ps
module rcg_gap_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         idle
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= span - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign idle = (cnt == '0);
endmodule

// File: rtl/rcg_act_window.sv
`timescale 1ns/1ps
module rcg_act_window #(
  parameter int DEPTH = 4,
  parameter int W     = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_go,
  input  logic [W-1:0] span,
  output logic         open
);
  logic [DEPTH-1:0] idle_v;
  logic [DEPTH-1:0] pick;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idle_v[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign open = |idle_v;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rcg_gap_timer #(.W(W)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .load (act_go && pick[g]),
      .span (span),
      .idle (idle_v[g])
    );
  end
endmodule

// File: rtl/rank_cmd_gate.sv
`timescale 1ns/1ps
module rank_cmd_gate
  import rcg_pkg::*;
#(
  parameter int ACT_WIN_DEPTH = ACT_LIMIT
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_type,
  output logic        cmd_ready
);
  logic [TW-1:0] rrd_q, win_q, w2r_q, r2p_q;
  logic go, act_go, rd_go, wr_go;
  logic rrd_idle, win_open, w2r_idle, r2p_idle;

  rcg_cfg_clamp u_clamp (
    .cfg_word(cfg_word),
    .rrd_q   (rrd_q),
    .win_q   (win_q),
    .w2r_q   (w2r_q),
    .r2p_q   (r2p_q)
  );

  assign go     = cmd_valid && cmd_ready;
  assign act_go = go && (cmd_type == CMD_ACT);
  assign rd_go  = go && (cmd_type == CMD_RD);
  assign wr_go  = go && (cmd_type == CMD_WR);

  rcg_gap_timer #(.W(TW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_go), .span(rrd_q), .idle(rrd_idle)
  );

  rcg_gap_timer #(.W(TW)) u_w2r (
    .clk(clk), .rst_n(rst_n), .load(wr_go), .span(w2r_q), .idle(w2r_idle)
  );

  rcg_gap_timer #(.W(TW)) u_r2p (
    .clk(clk), .rst_n(rst_n), .load(rd_go), .span(r2p_q), .idle(r2p_idle)
  );

  rcg_act_window #(.DEPTH(ACT_WIN_DEPTH), .W(TW)) u_win (
    .clk(clk), .rst_n(rst_n), .act_go(act_go), .span(win_q), .open(win_open)
  );

  always_comb begin
    unique case (cmd_type)
      CMD_ACT: cmd_ready = rrd_idle && win_open;
      CMD_RD:  cmd_ready = w2r_idle;
      CMD_WR:  cmd_ready = 1'b1;
      default: cmd_ready = r2p_idle;
    endcase
  end
endmodule

// File: rtl/rcg_checker.sv
`timescale 1ns/1ps
module rcg_checker
  import rcg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_type,
  input logic [TW-1:0] rrd_q,
  input logic [TW-1:0] win_q,
  input logic [TW-1:0] w2r_q,
  input logic [TW-1:0] r2p_q
);
  localparam int AW = 8;

  function automatic logic [AW-1:0] sat(input logic [AW-1:0] x);
    return (x == '1) ? x : x + AW'(1);
  endfunction

  logic act_go, rd_go, wr_go, pre_go;
  assign act_go = cmd_valid && cmd_ready && (cmd_type == CMD_ACT);
  assign rd_go  = cmd_valid && cmd_ready && (cmd_type == CMD_RD);
  assign wr_go  = cmd_valid && cmd_ready && (cmd_type == CMD_WR);
  assign pre_go = cmd_valid && cmd_ready && (cmd_type == CMD_PRE);

  logic [AW-1:0] since_act, since_wr, since_rd;
  logic [AW-1:0] gap_act, gap_wr, gap_rd;
  logic          seen_act, seen_wr, seen_rd;
  logic [AW-1:0] age [DEPTH];
  logic [AW-1:0] wn  [DEPTH];
  logic [$clog2(DEPTH+1)-1:0] act_n;
  logic          any_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '0; since_wr <= '0; since_rd <= '0;
      gap_act <= '0; gap_wr <= '0; gap_rd <= '0;
      seen_act <= 1'b0; seen_wr <= 1'b0; seen_rd <= 1'b0;
      act_n <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        age[i] <= '0;
        wn[i]  <= '0;
      end
    end else begin
      since_act <= act_go ? AW'(1) : sat(since_act);
      since_wr  <= wr_go  ? AW'(1) : sat(since_wr);
      since_rd  <= rd_go  ? AW'(1) : sat(since_rd);
      if (act_go) begin gap_act <= AW'(rrd_q); seen_act <= 1'b1; end
      if (wr_go)  begin gap_wr  <= AW'(w2r_q); seen_wr  <= 1'b1; end
      if (rd_go)  begin gap_rd  <= AW'(r2p_q); seen_rd  <= 1'b1; end
      if (act_go) begin
        age[0] <= AW'(1);
        wn[0]  <= AW'(win_q);
        for (int i = 1; i < DEPTH; i++) begin
          age[i] <= sat(age[i-1]);
          wn[i]  <= wn[i-1];
        end
        if (act_n != DEPTH[$clog2(DEPTH+1)-1:0]) act_n <= act_n + 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) age[i] <= sat(age[i]);
      end
    end
  end

  always_comb begin
    any_exp = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (age[i] >= wn[i]) any_exp = 1'b1;
  end

  AST_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    act_go && seen_act |-> since_act >= gap_act); // R2
  AST_ACT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    act_go && (act_n == DEPTH[$clog2(DEPTH+1)-1:0]) |-> any_exp); // R3
  AST_WR_TO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go && seen_wr |-> since_wr >= gap_wr); // R4
  AST_RD_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_go && seen_rd |-> since_rd >= gap_rd); // R5
  AST_WR_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_type == CMD_WR |-> cmd_ready); // R6
  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rrd_q >= TW'(RRD_MIN) && rrd_q <= TW'(RRD_MAX) && w2r_q >= TW'(TURN_MIN) && w2r_q <= TW'(TURN_MAX)
    && r2p_q >= TW'(TURN_MIN) && r2p_q <= TW'(TURN_MAX)); // R7
  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_q >= {rrd_q[TW-3:0], 2'b00} && win_q <= TW'(WIN_MAX)); // R8
endmodule

bind rank_cmd_gate rcg_checker #(.DEPTH(ACT_WIN_DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_type (cmd_type),
  .rrd_q    (rrd_q),
  .win_q    (win_q),
  .w2r_q    (w2r_q),
  .r2p_q    (r2p_q)
);

// File: tb/sim_rank_cmd_gate.sv
`timescale 1ns/1ps
module sim_rank_cmd_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = 32'h0010_4044;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_type = 2'd0;
  logic        cmd_ready;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  always #10 clk = ~clk;

  rank_cmd_gate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_ready(cmd_ready)
  );

  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic logic [31:0] mk_cfg(input int win, input int w2r, input int r2p, input int rrd);
    return {8'hA5, 8'(win), 4'(w2r), 4'hF, 4'(r2p), 4'(rrd)};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Offer a command until accepted; waited = cycles from the previous cycle to acceptance
  task automatic issue(input logic [1:0] t, output int waited);
    waited = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_type  = t;
    forever begin
      #1;
      waited++;
      if (cmd_ready || waited > 300) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int w;
    int t_acc [8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every type ready after reset
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      cmd_type = 2'(t);
      #1;
      chk("R1 ready after reset", int'(cmd_ready), 1);
    end

    // R2 / R7: ACT spacing over every field value
    for (int f = 0; f < 16; f++) begin
      cfg_word = mk_cfg(0, 4, 4, f);
      issue(ACT, w);
      chk("R1 first ACT", w, 1);
      issue(ACT, w);
      chk("R2 R7 ACT gap", w, lim(f, 4, 7));
      idle(70);
    end

    // R4 / R7: write-to-read
    for (int f = 0; f < 16; f++) begin
      cfg_word = mk_cfg(16, f, 4, 4);
      issue(WR, w);
      issue(RD, w);
      chk("R4 R7 WR to RD", w, lim(f, 4, 8));
      idle(20);
    end

    // R5 / R7: read-to-precharge
    for (int f = 0; f < 16; f++) begin
      cfg_word = mk_cfg(16, 4, f, 4);
      issue(RD, w);
      issue(PRE, w);
      chk("R5 R7 RD to PRE", w, lim(f, 4, 8));
      idle(20);
    end

    // R3 / R8: rolling activate window, back-to-back bursts of 8
    for (int r = 4; r < 8; r++) begin
      for (int k = 0; k < 8; k++) begin
        int fl [8] = '{0, 12, 16, 17, 25, 40, 63, 200};
        int winc;
        winc = lim(fl[k], 0, 63);
        if (winc < 4 * r) winc = 4 * r;
        cfg_word = mk_cfg(fl[k], 4, 4, r);
        t_acc[0] = 0;
        issue(ACT, w);
        for (int a = 1; a < 8; a++) begin
          t_acc[a] = t_acc[a-1] + r;
          if (a >= 4 && t_acc[a-4] + winc > t_acc[a]) t_acc[a] = t_acc[a-4] + winc;
          issue(ACT, w);
          chk("R3 R8 ACT window gap", w, t_acc[a] - t_acc[a-1]);
        end
        idle(70);
      end
    end

    // R6: writes never held, other types unaffected by unrelated rules
    cfg_word = mk_cfg(16, 8, 8, 7);
    for (int i = 0; i < 4; i++) begin
      issue(WR, w);
      chk("R6 WR never held", w, 1);
    end
    issue(ACT, w);
    chk("R6 ACT not held by WR", w, 1);
    issue(PRE, w);
    chk("R6 PRE not held by WR or ACT", w, 1);
    issue(WR, w);
    chk("R6 WR not held by ACT", w, 1);
    idle(70);

    // R9: config change does not move running intervals
    cfg_word = mk_cfg(0, 4, 4, 7);
    issue(ACT, w);
    cfg_word = mk_cfg(0, 4, 4, 4);
    issue(ACT, w);
    chk("R9 ACT keeps old gap", w, 7);
    issue(ACT, w);
    chk("R9 ACT uses new gap", w, 4);
    idle(70);
    cfg_word = mk_cfg(16, 8, 4, 4);
    issue(WR, w);
    cfg_word = mk_cfg(16, 4, 4, 4);
    issue(RD, w);
    chk("R9 RD keeps old turnaround", w, 8);
    idle(70);

    // R10: no acceptance without valid; encoding of cmd_type
    cfg_word = mk_cfg(16, 4, 4, 4);
    issue(ACT, w);
    @(negedge clk);
    cmd_type = ACT;
    #1;
    chk("R10 ACT code 0 held after ACT", int'(cmd_ready), 0);
    cmd_type = WR;
    #1;
    chk("R10 WR code 2 ready", int'(cmd_ready), 1);
    idle(10);
    cmd_type = ACT;
    cmd_valid = 1'b0;
    idle(10);
    #1;
    chk("R10 ready while not valid", int'(cmd_ready), 1);
    issue(ACT, w);
    chk("R10 idle cycles start nothing", w, 1);
    issue(ACT, w);
    chk("R10 gap after valid ACT", w, 4);
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule